// File: doc/BRIEF.md
# Outstanding Write Response Tracker

This block sits beside the write path of a memory-to-memory transfer channel. It counts bus writes that have been issued but not yet answered by a write response. From that count it decides whether the datapath may issue another write. It also decides when the end of a transfer can be reported to the descriptor sequencer. The bus protocol itself lies outside the block: it sees only a one-cycle pulse per issued write and a one-cycle pulse per returned response.

Two mode bits select the policy. With drain-at-end set, issue stalls once more than a threshold of writes are in flight, and the stall shows on a paused output. When the datapath signals that the transfer is finished, the block holds the completion pulse back until every response has come home. While holding it back, it raises a waiting status and blocks further writes. The sequencer may meanwhile latch the next descriptor pointer, or drop its active flag for a null pointer, but it must not fetch the next descriptor until the completion pulse arrives. With wait-per-write set, a new write is allowed only when nothing is outstanding. A response that arrives when nothing is outstanding is dropped and flagged.

Top module: `wr_outstanding_tracker`

## Requirements
- R1: After synchronous reset the in-flight count is 0; write-allowed is 1 with both modes clear; waiting, completion and the error flag are 0.
- R2: The count rises by exactly one on a cycle with an issue pulse and no response pulse, and falls by exactly one on a cycle with a response pulse and no issue pulse. Both changes are visible after that clock edge.
- R3: An issue pulse and a response pulse in the same cycle leave the count unchanged.
- R4: A response pulse with no issue pulse while the count is 0 leaves the count at 0 and sets the error flag. The flag stays set until reset.
- R5: With drain-at-end set, write-allowed is 0 and paused is 1 exactly while the count exceeds STALL_LIMIT (13 by default). With the mode clear, paused is 0.
- R6: With wait-per-write set, write-allowed is 1 only while the count is 0.
- R7: With both modes clear and no drain in progress, write-allowed is 1 at every count, including the saturated maximum.
- R8: With drain-at-end set, a transfer-finished pulse while writes remain outstanding raises waiting and withholds the completion pulse. The completion pulse appears for one cycle after the edge at which the count reaches 0, and waiting drops at the same edge. If the count is already 0, the completion pulse follows the finished pulse at the next edge.
- R9: While waiting is 1, write-allowed is 0.
- R10: With drain-at-end clear, the completion pulse follows the transfer-finished pulse at the next edge, whatever the count.
- R11: The count saturates at 2**CNT_W-1 and never wraps to 0 on further issue pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high channel reset |
| drain_mode | input | 1 | Hold completion until all responses return; stall issue above the limit |
| per_write_mode | input | 1 | Allow a new write only when none is outstanding |
| wr_issue | input | 1 | One-cycle pulse per write issued |
| wr_resp | input | 1 | One-cycle pulse per write response received |
| xfer_done | input | 1 | One-cycle pulse when the datapath has sent the last data |
| wr_allow | output | 1 | Datapath may issue a write this cycle |
| waiting | output | 1 | Transfer finished, waiting for outstanding responses |
| paused | output | 1 | Issue stalled by the in-flight limit |
| done_q | output | 1 | Qualified completion pulse to the descriptor sequencer |
| resp_err | output | 1 | Sticky flag: response received with nothing outstanding |
| inflight | output | CNT_W | Current in-flight write count |

## Verification
The bench builds the block with its defaults: a 5-bit counter and a stall limit of 13. This keeps both edges of the counter within a few dozen cycles. Fourteen back-to-back issues cross the stall threshold. Thirty-three issues drive the count past saturation at 31. A drain with thirteen responses still pending exercises a long hold of the completion pulse and the exact edge at which it is released.

// File: rtl/wtrk_pkg.sv
package wtrk_pkg;

    typedef enum logic {
        TRK_RUN   = 1'b0,
        TRK_DRAIN = 1'b1
    } trk_state_e;

    typedef struct packed {
        logic issue;
        logic resp;
    } trk_evt_t;

    typedef enum logic [1:0] {
        CNT_HOLD = 2'd0,
        CNT_UP   = 2'd1,
        CNT_DOWN = 2'd2,
        CNT_BAD  = 2'd3
    } cnt_op_e;

    // Classify one cycle of bus events against the current count.
    function automatic cnt_op_e classify(trk_evt_t e, logic is_zero);
        if (e.issue && !e.resp)
            return CNT_UP;
        if (e.resp && !e.issue)
            return is_zero ? CNT_BAD : CNT_DOWN;
        return CNT_HOLD;
    endfunction

endpackage

// File: rtl/wtrk_counter.sv
module wtrk_counter
    import wtrk_pkg::*;
#(
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  trk_evt_t         evt,
    output logic [CNT_W-1:0] count,
    output logic [CNT_W-1:0] count_nxt,
    output logic             err
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] ONE     = CNT_W'(1);

    cnt_op_e op;

    always_comb begin
        op        = classify(evt, count == '0);
        count_nxt = count;
        unique case (op)
            CNT_UP:   if (count != CNT_MAX) count_nxt = count + ONE;
            CNT_DOWN: count_nxt = count - ONE;
            default:  count_nxt = count;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            count <= '0;
            err   <= 1'b0;
        end else begin
            count <= count_nxt;
            if (op == CNT_BAD)
                err <= 1'b1;
        end
    end
endmodule

// File: rtl/wtrk_issue_gate.sv
module wtrk_issue_gate #(
    parameter int CNT_W       = 5,
    parameter int STALL_LIMIT = 13
) (
    input  logic             drain_mode,
    input  logic             per_write_mode,
    input  logic             draining,
    input  logic [CNT_W-1:0] count,
    output logic             allow,
    output logic             limit_stall
);
    localparam logic [CNT_W-1:0] LIMIT_V = CNT_W'(STALL_LIMIT);

    logic single_block;

    always_comb begin
        limit_stall  = drain_mode && (count > LIMIT_V);
        single_block = per_write_mode && (count != '0);
        allow        = !(draining || limit_stall || single_block);
    end
endmodule

// File: rtl/wtrk_done_gate.sv
module wtrk_done_gate
    import wtrk_pkg::*;
#(
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             drain_mode,
    input  logic             xfer_done,
    input  logic [CNT_W-1:0] count_nxt,
    output logic             waiting,
    output logic             done_q
);
    trk_state_e state, state_nxt;
    logic       done_nxt;
    logic       drained;

    always_comb begin
        drained   = (count_nxt == '0);
        state_nxt = state;
        done_nxt  = 1'b0;
        unique case (state)
            TRK_DRAIN: begin
                if (drained) begin
                    state_nxt = TRK_RUN;
                    done_nxt  = 1'b1;
                end
            end
            default: begin
                if (xfer_done) begin
                    if (drain_mode && !drained)
                        state_nxt = TRK_DRAIN;
                    else
                        done_nxt = 1'b1;
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= TRK_RUN;
            done_q <= 1'b0;
        end else begin
            state  <= state_nxt;
            done_q <= done_nxt;
        end
    end

    assign waiting = (state == TRK_DRAIN);
endmodule

// File: rtl/wr_outstanding_tracker.sv
module wr_outstanding_tracker
    import wtrk_pkg::*;
#(
    parameter int CNT_W       = 5,
    parameter int STALL_LIMIT = 13
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             drain_mode,
    input  logic             per_write_mode,
    input  logic             wr_issue,
    input  logic             wr_resp,
    input  logic             xfer_done,
    output logic             wr_allow,
    output logic             waiting,
    output logic             paused,
    output logic             done_q,
    output logic             resp_err,
    output logic [CNT_W-1:0] inflight
);
    trk_evt_t         evt;
    logic [CNT_W-1:0] count_nxt;

    assign evt.issue = wr_issue;
    assign evt.resp  = wr_resp;

    wtrk_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk       (clk),
        .rst       (rst),
        .evt       (evt),
        .count     (inflight),
        .count_nxt (count_nxt),
        .err       (resp_err)
    );

    wtrk_done_gate #(.CNT_W(CNT_W)) u_done (
        .clk        (clk),
        .rst        (rst),
        .drain_mode (drain_mode),
        .xfer_done  (xfer_done),
        .count_nxt  (count_nxt),
        .waiting    (waiting),
        .done_q     (done_q)
    );

    wtrk_issue_gate #(.CNT_W(CNT_W), .STALL_LIMIT(STALL_LIMIT)) u_gate (
        .drain_mode     (drain_mode),
        .per_write_mode (per_write_mode),
        .draining       (waiting),
        .count          (inflight),
        .allow          (wr_allow),
        .limit_stall    (paused)
    );
endmodule

// File: rtl/wr_outstanding_tracker_chk.sv
module wr_outstanding_tracker_chk #(
    parameter int CNT_W       = 5,
    parameter int STALL_LIMIT = 13
) (
    input logic             clk,
    input logic             rst,
    input logic             drain_mode,
    input logic             per_write_mode,
    input logic             wr_issue,
    input logic             wr_resp,
    input logic             xfer_done,
    input logic             wr_allow,
    input logic             waiting,
    input logic             paused,
    input logic             done_q,
    input logic             resp_err,
    input logic [CNT_W-1:0] inflight
);
    localparam logic [CNT_W-1:0] LIMIT_V = CNT_W'(STALL_LIMIT);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] ONE     = CNT_W'(1);

    // R1
    reset_state_chk: assert property (@(posedge clk)
        $past(rst) |-> (inflight == '0 && !waiting && !done_q && !resp_err));

    // R2
    inc_step_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_issue && !wr_resp && inflight != CNT_MAX) |=> inflight == $past(inflight) + ONE);

    // R2
    dec_step_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_resp && !wr_issue && inflight != '0) |=> inflight == $past(inflight) - ONE);

    // R3
    both_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_resp && wr_issue) |=> $stable(inflight));

    // R4
    underflow_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_resp && !wr_issue && inflight == '0) |=> (inflight == '0 && resp_err));

    // R4
    err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        resp_err |=> resp_err);

    // R5
    limit_stall_chk: assert property (@(posedge clk) disable iff (rst)
        (drain_mode && inflight > LIMIT_V) |-> (!wr_allow && paused));

    // R6
    per_write_chk: assert property (@(posedge clk) disable iff (rst)
        (per_write_mode && inflight != '0) |-> !wr_allow);

    // R8
    hold_done_chk: assert property (@(posedge clk) disable iff (rst)
        waiting |-> !done_q);

    // R9
    wait_block_chk: assert property (@(posedge clk) disable iff (rst)
        waiting |-> !wr_allow);

    // R11
    no_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (inflight == CNT_MAX && !wr_resp) |=> inflight == CNT_MAX);
endmodule

bind wr_outstanding_tracker wr_outstanding_tracker_chk #(
    .CNT_W(CNT_W), .STALL_LIMIT(STALL_LIMIT)
) u_chk (
    .clk(clk), .rst(rst), .drain_mode(drain_mode), .per_write_mode(per_write_mode),
    .wr_issue(wr_issue), .wr_resp(wr_resp), .xfer_done(xfer_done),
    .wr_allow(wr_allow), .waiting(waiting), .paused(paused), .done_q(done_q),
    .resp_err(resp_err), .inflight(inflight)
);

// File: tb/wr_outstanding_tracker_tb.sv
module wr_outstanding_tracker_tb;
    localparam int CLK_PERIOD = 10;
    localparam int CNT_W      = 5;
    localparam int LIMIT      = 13;
    localparam int CMAX       = (1 << CNT_W) - 1;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic drain_mode = 1'b0, per_write_mode = 1'b0;
    logic wr_issue = 1'b0, wr_resp = 1'b0, xfer_done = 1'b0;
    logic wr_allow, waiting, paused, done_q, resp_err;
    logic [CNT_W-1:0] inflight;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    typedef struct {
        int    cnt;
        bit    allow;
        bit    wt;
        bit    done;
        bit    err;
        bit    pau;
        string tag;
    } exp_t;

    exp_t q[$];

    // reference state, derived from the requirements
    int m_cnt  = 0;
    bit m_err  = 0;
    bit m_wait = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    wr_outstanding_tracker #(.CNT_W(CNT_W), .STALL_LIMIT(LIMIT)) u_dut (
        .clk(clk), .rst(rst), .drain_mode(drain_mode), .per_write_mode(per_write_mode),
        .wr_issue(wr_issue), .wr_resp(wr_resp), .xfer_done(xfer_done),
        .wr_allow(wr_allow), .waiting(waiting), .paused(paused), .done_q(done_q),
        .resp_err(resp_err), .inflight(inflight)
    );

    task automatic cmp(input string tag, input string field, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, field, act, exp);
        end
    endtask

    // monitor: pops one expected item per cycle and compares at the falling edge
    initial begin
        forever begin
            @(negedge clk);
            if (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                cmp(e.tag, "inflight", int'(inflight), e.cnt);
                cmp(e.tag, "wr_allow", int'(wr_allow), int'(e.allow));
                cmp(e.tag, "waiting",  int'(waiting),  int'(e.wt));
                cmp(e.tag, "done_q",   int'(done_q),   int'(e.done));
                cmp(e.tag, "resp_err", int'(resp_err), int'(e.err));
                cmp(e.tag, "paused",   int'(paused),   int'(e.pau));
            end
        end
    end

    // driver: applies one cycle of stimulus and pushes what must be seen after the edge
    task automatic step(input bit r, input bit iss, input bit rsp, input bit xd,
                        input bit dm, input bit pw, input string tag);
        exp_t e;
        int   nxt;
        bit   dn;
        @(negedge clk);
        #1;
        rst = r; wr_issue = iss; wr_resp = rsp; xfer_done = xd;
        drain_mode = dm; per_write_mode = pw;
        dn = 0;
        if (r) begin
            m_cnt = 0; m_err = 0; m_wait = 0;
        end else begin
            nxt = m_cnt;
            if (iss && !rsp) nxt = (m_cnt == CMAX) ? m_cnt : m_cnt + 1;
            else if (rsp && !iss) begin
                if (m_cnt == 0) m_err = 1;
                else nxt = m_cnt - 1;
            end
            if (m_wait) begin
                if (nxt == 0) begin m_wait = 0; dn = 1; end
            end else if (xd) begin
                if (dm && nxt != 0) m_wait = 1;
                else dn = 1;
            end
            m_cnt = nxt;
        end
        e.cnt   = m_cnt;
        e.wt    = m_wait;
        e.done  = dn;
        e.err   = m_err;
        e.pau   = dm && (m_cnt > LIMIT);
        e.allow = !(m_wait || (dm && m_cnt > LIMIT) || (pw && m_cnt != 0));
        e.tag   = tag;
        q.push_back(e);
    endtask

    initial begin
        // R1 reset state
        step(1, 0, 0, 0, 0, 0, "R1");
        step(0, 0, 0, 0, 0, 0, "R1");
        // R2 count up and down
        for (int i = 0; i < 3; i++) step(0, 1, 0, 0, 0, 0, "R2");
        step(0, 0, 1, 0, 0, 0, "R2");
        // R3 simultaneous issue and response
        step(0, 1, 1, 0, 0, 0, "R3");
        step(0, 1, 1, 0, 0, 0, "R3");
        step(0, 0, 1, 0, 0, 0, "R2");
        step(0, 0, 1, 0, 0, 0, "R2");
        // R4 response with nothing outstanding
        step(0, 0, 1, 0, 0, 0, "R4");
        step(0, 0, 0, 0, 0, 0, "R4");
        step(0, 1, 0, 0, 0, 0, "R4");
        // R10 completion without drain mode while writes are pending
        step(0, 1, 0, 0, 0, 0, "R10");
        step(0, 0, 0, 1, 0, 0, "R10");
        step(0, 0, 0, 0, 0, 0, "R10");
        // R1 reset clears the sticky flag and the count
        step(1, 0, 0, 0, 0, 0, "R1");
        // R5 drain mode stall above the limit
        for (int i = 0; i < LIMIT; i++) step(0, 1, 0, 0, 1, 0, "R5");
        step(0, 1, 0, 0, 1, 0, "R5");
        step(0, 0, 0, 0, 1, 0, "R5");
        step(0, 0, 1, 0, 1, 0, "R5");
        step(0, 0, 0, 0, 0, 0, "R5");
        // R8 R9 drain with responses still pending
        step(0, 0, 0, 1, 1, 0, "R8");
        step(0, 0, 0, 0, 1, 0, "R9");
        for (int i = 0; i < LIMIT - 1; i++) step(0, 0, 1, 0, 1, 0, "R8");
        step(0, 0, 1, 0, 1, 0, "R8");
        step(0, 0, 0, 0, 1, 0, "R8");
        // R8 drain with nothing pending completes at once
        step(0, 0, 0, 1, 1, 0, "R8");
        step(0, 0, 0, 0, 1, 0, "R8");
        // R6 wait-per-write mode
        step(0, 1, 0, 0, 0, 1, "R6");
        step(0, 0, 0, 0, 0, 1, "R6");
        step(0, 0, 1, 0, 0, 1, "R6");
        // R11 R7 saturation with both modes clear
        for (int i = 0; i < CMAX + 2; i++) step(0, 1, 0, 0, 0, 0, "R11");
        step(0, 0, 0, 0, 0, 0, "R7");
        step(0, 0, 1, 0, 0, 0, "R11");
        step(0, 0, 0, 0, 0, 0, "R7");
        repeat (3) @(negedge clk);
        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 20000);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule